// File: doc/BRIEF.md
# Min-Sum Check Node Unit

This block performs the check-node half of an iterative min-sum decoder for a low-density parity-check code. One check node has up to `DEG` edges. On every cycle the block takes one signed soft message per edge, arriving from the variable nodes, together with an enable bit per edge. It returns one signed message per edge, going back to the variable nodes. Each returned message leaves out the contribution of its own edge. Its sign is the parity of the signs on all the other enabled edges. Its magnitude is the smallest magnitude found on those other edges.

The magnitudes are found in a single pass. That pass records the smallest magnitude, the second smallest, and the position of the smallest. The edge that holds the smallest value receives the second smallest, and every other edge receives the smallest. No nonlinear function table is used. The outputs pass through an optional register, selected by the parameter `OUT_REG` (default 1), so that a decoder can place the unit inside a pipelined datapath. The unit does not do variable-node arithmetic, scheduling or message storage.

Top module: `msum_check_unit`

## Requirements
- R1: A message is negative when its sign bit (bit `MW-1`) is 1, which favours bit value 1. A zero or positive message favours 0. For each enabled edge i, the output is negative exactly when an odd number of the other enabled inputs are negative, unless the output magnitude is zero.
- R2: For each enabled edge i, the output magnitude equals the smallest saturated magnitude among the other enabled inputs.
- R3: An input of -32 (the most negative 6-bit code) is treated as magnitude 31. No output ever carries the code -32.
- R4: When two or more enabled edges share the smallest magnitude, every enabled edge receives that magnitude, including the tied edges themselves.
- R5: An edge whose enable bit is 0 gets an output of 0. Its input has no effect on the sign or magnitude of any other edge. With no edge enabled, all outputs are 0.
- R6: When exactly one edge is enabled, its output is +31.
- R7: An enabled input of 0 gives magnitude 0 to every other enabled edge, and such outputs are 0.
- R8: With `OUT_REG`=1, the outputs reflect the inputs present at the previous rising clock edge. A synchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| v2c_msg | input | DEG*MW | Incoming two's-complement messages, edge 0 in the lowest bits |
| edge_en | input | DEG | Per-edge enable, bit i enables edge i |
| c2v_msg | output | DEG*MW | Outgoing two's-complement messages, edge 0 in the lowest bits |

## Verification
The internal state that can go wrong is the triple of smallest value, second-smallest value and index of the smallest. A wrong index gives the minimum edge its own magnitude back, and a stale second-smallest value breaks ties. Both errors appear at the ports one clock after the offending input vector. The bench therefore drives tied minima, saturated inputs, zero inputs and masked small values, and compares every edge on every cycle against a brute-force model. A faulty sign parity flips the sign of every enabled edge in that same cycle.

// File: rtl/msum_pkg.sv
// Package: shared constants and helpers for the min-sum check node unit.
// Assumes two's-complement messages; magnitudes are one bit narrower.
package msum_pkg;

    localparam int MSUM_DEG_DEF = 4;
    localparam int MSUM_MW_DEF  = 6;

    // Width of an edge index for a given degree (at least one bit).
    function automatic int msum_idx_w(input int deg);
        return (deg > 1) ? $clog2(deg) : 1;
    endfunction

endpackage

// File: rtl/msum_edge_prep.sv
// Module: msum_edge_prep
// Turns one incoming message into a saturated magnitude and a sign flag.
// A disabled edge presents the largest magnitude and a positive sign, so
// it can never become a minimum and never flips a parity.
module msum_edge_prep #(
    parameter int MW = 6,
    localparam int MAGW = MW - 1
) (
    input  logic [MW-1:0]   msg,
    input  logic            en,
    output logic [MAGW-1:0] mag,
    output logic            neg
);

    localparam logic [MAGW-1:0] MAG_MAX = {MAGW{1'b1}};

    logic [MW-1:0] flipped;

    // Form the two's-complement negation of the message.
    always_comb begin
        flipped = ~msg + MW'(1);
    end

    // Select the saturated magnitude and the masked sign.
    always_comb begin
        if (!en) begin
            mag = MAG_MAX;
            neg = 1'b0;
        end else if (msg[MW-1]) begin
            neg = 1'b1;
            if (flipped[MW-1]) begin
                mag = MAG_MAX;
            end else begin
                mag = flipped[MAGW-1:0];
            end
        end else begin
            neg = 1'b0;
            mag = msg[MAGW-1:0];
        end
    end

endmodule

// File: rtl/msum_min_scan.sv
// Module: msum_min_scan
// Single pass over all edge magnitudes. Finds the smallest value, the
// second smallest and the index of the smallest. A tie with the current
// smallest goes to the second-smallest slot, so tied minima give min2 == min1.
module msum_min_scan #(
    parameter int DEG  = 4,
    parameter int MAGW = 5,
    parameter int IDXW = 2
) (
    input  logic [DEG*MAGW-1:0] mags,
    output logic [MAGW-1:0]     min1,
    output logic [MAGW-1:0]     min2,
    output logic [IDXW-1:0]     min1_idx
);

    localparam logic [MAGW-1:0] MAG_MAX = {MAGW{1'b1}};

    // Walk the edges in order and update the two running minima.
    always_comb begin
        logic [MAGW-1:0] cur;
        min1     = MAG_MAX;
        min2     = MAG_MAX;
        min1_idx = '0;
        for (int i = 0; i < DEG; i++) begin
            cur = mags[i*MAGW +: MAGW];
            if (cur < min1) begin
                min2     = min1;
                min1     = cur;
                min1_idx = IDXW'(i);
            end else if (cur < min2) begin
                min2 = cur;
            end
        end
    end

endmodule

// File: rtl/msum_edge_out.sv
// Module: msum_edge_out
// Builds the outgoing message for one edge. The magnitude is min2 when this
// edge holds the minimum and min1 otherwise. The sign is the total parity
// with this edge's own sign removed. A disabled edge outputs zero.
module msum_edge_out #(
    parameter int MW   = 6,
    parameter int IDXW = 2,
    parameter int ID   = 0,
    localparam int MAGW = MW - 1
) (
    input  logic [MAGW-1:0] min1,
    input  logic [MAGW-1:0] min2,
    input  logic [IDXW-1:0] min1_idx,
    input  logic            par_all,
    input  logic            own_neg,
    input  logic            en,
    output logic [MW-1:0]   msg
);

    logic [MAGW-1:0] sel_mag;
    logic            sel_neg;
    logic [MW-1:0]   wide_mag;

    // Choose the magnitude that excludes this edge.
    always_comb begin
        sel_mag = (min1_idx == IDXW'(ID)) ? min2 : min1;
    end

    // Remove this edge's sign from the total parity.
    always_comb begin
        sel_neg = par_all ^ own_neg;
    end

    // Apply the sign and the enable mask.
    always_comb begin
        wide_mag = {1'b0, sel_mag};
        if (!en) begin
            msg = '0;
        end else if (sel_neg) begin
            msg = MW'(0) - wide_mag;
        end else begin
            msg = wide_mag;
        end
    end

endmodule

// File: rtl/msum_check_unit.sv
// Module: msum_check_unit (top)
// Min-sum check node update for up to DEG edges. The outputs are registered
// when OUT_REG is 1, with a synchronous active-low reset to zero; with
// OUT_REG at 0 the path is purely combinational. Edge i uses bits
// [i*MW +: MW] of each message bus.
module msum_check_unit
    import msum_pkg::*;
#(
    parameter int DEG     = MSUM_DEG_DEF,
    parameter int MW      = MSUM_MW_DEF,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEG*MW-1:0] v2c_msg,
    input  logic [DEG-1:0]    edge_en,
    output logic [DEG*MW-1:0] c2v_msg
);

    localparam int MAGW = MW - 1;
    localparam int IDXW = msum_idx_w(DEG);

    logic [DEG*MAGW-1:0] mags;
    logic [DEG-1:0]      negs;
    logic [MAGW-1:0]     min1;
    logic [MAGW-1:0]     min2;
    logic [IDXW-1:0]     min1_idx;
    logic                par_all;
    logic [DEG*MW-1:0]   c2v_comb;

    // Per-edge magnitude and sign extraction.
    for (genvar g = 0; g < DEG; g++) begin : g_prep
        msum_edge_prep #(.MW(MW)) u_prep (
            .msg (v2c_msg[g*MW +: MW]),
            .en  (edge_en[g]),
            .mag (mags[g*MAGW +: MAGW]),
            .neg (negs[g])
        );
    end

    // Two smallest magnitudes and the position of the smallest.
    msum_min_scan #(.DEG(DEG), .MAGW(MAGW), .IDXW(IDXW)) u_scan (
        .mags     (mags),
        .min1     (min1),
        .min2     (min2),
        .min1_idx (min1_idx)
    );

    // Parity of all enabled signs.
    always_comb begin
        par_all = ^negs;
    end

    // Per-edge output formation.
    for (genvar g = 0; g < DEG; g++) begin : g_out
        msum_edge_out #(.MW(MW), .IDXW(IDXW), .ID(g)) u_out (
            .min1     (min1),
            .min2     (min2),
            .min1_idx (min1_idx),
            .par_all  (par_all),
            .own_neg  (negs[g]),
            .en       (edge_en[g]),
            .msg      (c2v_comb[g*MW +: MW])
        );
    end

    // Optional output register, chosen by OUT_REG.
    if (OUT_REG) begin : g_reg
        // Capture the combinational result; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c2v_msg <= '0;
            end else begin
                c2v_msg <= c2v_comb;
            end
        end
    end else begin : g_noreg
        assign c2v_msg = c2v_comb;
    end

endmodule

// File: rtl/msum_check_unit_chk.sv
// Module: msum_check_unit_chk
// Property checker bound to msum_check_unit. It keeps its own copy of the
// inputs that gave the current outputs (one cycle back when OUT_REG is 1)
// and relates them to the outputs.
module msum_check_unit_chk #(
    parameter int DEG     = 4,
    parameter int MW      = 6,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DEG*MW-1:0] v2c_msg,
    input logic [DEG-1:0]    edge_en,
    input logic [DEG*MW-1:0] c2v_msg
);

    localparam int MAXMAG = (1 << (MW - 1)) - 1;

    logic [DEG*MW-1:0] obs_msg;
    logic [DEG-1:0]    obs_en;
    logic              obs_ok;

    // Saturated magnitude of a message, as an integer.
    function automatic int sat_abs(input logic [MW-1:0] v);
        int s;
        s = int'($signed(v));
        if (s < 0) begin
            s = -s;
        end
        return (s > MAXMAG) ? MAXMAG : s;
    endfunction

    if (OUT_REG) begin : g_obs_reg
        // Keep the inputs that produced the present outputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                obs_msg <= '0;
                obs_en  <= '0;
                obs_ok  <= 1'b0;
            end else begin
                obs_msg <= v2c_msg;
                obs_en  <= edge_en;
                obs_ok  <= 1'b1;
            end
        end
    end else begin : g_obs_comb
        assign obs_msg = v2c_msg;
        assign obs_en  = edge_en;
        assign obs_ok  = 1'b1;
    end

    for (genvar i = 0; i < DEG; i++) begin : g_edge
        // R5: a disabled edge outputs zero.
        a_r5_off_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (obs_ok && !obs_en[i]) |-> (c2v_msg[i*MW +: MW] == '0));

        // R3: the most negative code never appears on an output.
        a_r3_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
            c2v_msg[i*MW +: MW] != {1'b1, {(MW-1){1'b0}}});

        // R6: a lone enabled edge receives the largest positive value.
        a_r6_lone_edge_max: assert property (@(posedge clk) disable iff (!rst_n)
            (obs_ok && obs_en[i] && $countones(obs_en) == 1)
            |-> (c2v_msg[i*MW +: MW] == MW'(MAXMAG)));

        for (genvar j = 0; j < DEG; j++) begin : g_pair
            if (i != j) begin : g_other
                // R2: no output magnitude exceeds any other enabled input's.
                a_r2_mag_bound: assert property (@(posedge clk) disable iff (!rst_n)
                    (obs_ok && obs_en[i] && obs_en[j])
                    |-> (sat_abs(c2v_msg[i*MW +: MW]) <= sat_abs(obs_msg[j*MW +: MW])));
            end
        end
    end

endmodule

bind msum_check_unit msum_check_unit_chk #(
    .DEG(DEG), .MW(MW), .OUT_REG(OUT_REG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .v2c_msg (v2c_msg),
    .edge_en (edge_en),
    .c2v_msg (c2v_msg)
);

// File: tb/msum_check_unit_tb.sv
// Bench for msum_check_unit: brute-force behavioural model, compared on
// every clock (outputs registered, one cycle of latency).
module msum_check_unit_tb;

    localparam int DEG = 4;
    localparam int MW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DEG*MW-1:0] v2c_msg = '0;
    logic [DEG-1:0]    edge_en = '0;
    logic [DEG*MW-1:0] c2v_msg;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [DEG*MW-1:0] exp_q[$];
    string             tag_q[$];

    always #10 clk = ~clk;

    msum_check_unit #(.DEG(DEG), .MW(MW), .OUT_REG(1'b1)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .v2c_msg (v2c_msg),
        .edge_en (edge_en),
        .c2v_msg (c2v_msg)
    );

    // Brute force: for each enabled edge scan all other enabled edges.
    function automatic logic [DEG*MW-1:0] model(input logic [DEG*MW-1:0] m,
                                                input logic [DEG-1:0] en);
        logic [DEG*MW-1:0] r;
        r = '0;
        for (int i = 0; i < DEG; i++) begin
            int best;
            int neg;
            if (!en[i]) continue;
            best = 31;
            neg  = 0;
            for (int j = 0; j < DEG; j++) begin
                int v;
                if (j == i || !en[j]) continue;
                v = int'($signed(m[j*MW +: MW]));
                if (v < 0) begin
                    neg = neg ^ 1;
                    v = -v;
                end
                if (v > 31) v = 31;
                if (v < best) best = v;
            end
            r[i*MW +: MW] = MW'(neg ? -best : best);
        end
        return r;
    endfunction

    function automatic logic [DEG*MW-1:0] pack(input int a, input int b,
                                               input int c, input int d);
        return {MW'(d), MW'(c), MW'(b), MW'(a)};
    endfunction

    task automatic compare(input logic [DEG*MW-1:0] exp, input string tag);
        for (int i = 0; i < DEG; i++) begin
            checks++;
            if (c2v_msg[i*MW +: MW] !== exp[i*MW +: MW]) begin
                errors++;
                $display("FAIL %s edge %0d: actual=%0d expected=%0d", tag, i,
                         $signed(c2v_msg[i*MW +: MW]), $signed(exp[i*MW +: MW]));
            end
        end
    endtask

    // One cycle: check the result of the previous vector, then drive a new one.
    task automatic step(input logic [DEG*MW-1:0] m, input logic [DEG-1:0] en,
                        input string tag);
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        v2c_msg = m;
        edge_en = en;
        exp_q.push_back(model(m, en));
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R8: reset holds outputs at zero even with live inputs.
        v2c_msg = pack(3, -4, 5, -6);
        edge_en = 4'b1111;
        repeat (3) @(negedge clk);
        compare('0, "R8 reset");
        rst_n = 1'b1;

        step(pack(5, -3, 7, -9),    4'b1111, "R1 R2 mixed signs");
        step(pack(-2, -11, -6, -8), 4'b1111, "R1 all negative");
        step(pack(9, 14, 3, 20),    4'b1111, "R2 positive mins");
        step(pack(-32, 20, 25, 31), 4'b1111, "R3 saturation");
        step(pack(-32, -32, 30, 1), 4'b1111, "R3 double saturation");
        step(pack(4, -4, 10, 12),   4'b1111, "R4 tie");
        step(pack(7, 7, 7, 7),      4'b1111, "R4 four-way tie");
        step(pack(8, 12, -1, 9),    4'b1011, "R5 masked small");
        step(pack(-1, -2, 3, -4),   4'b0000, "R5 none enabled");
        step(pack(-5, 2, -7, 1),    4'b0100, "R6 lone edge");
        step(pack(0, 6, -8, 11),    4'b1111, "R7 zero input");
        step(pack(0, 0, -3, 2),     4'b1111, "R7 two zeros");
        step(pack(-13, 6, 2, 19),   4'b1001, "R5 two edges");
        // R8: back-to-back vectors each appear exactly one cycle later.
        for (int k = 0; k < 400; k++) begin
            step({$urandom, $urandom}[DEG*MW-1:0], 4'($urandom), "R1 R2 random");
        end
        step('0, '0, "R8 drain");
        // R8: a synchronous reset mid-run clears the outputs.
        @(negedge clk);
        v2c_msg = pack(1, 2, 3, 4);
        edge_en = 4'b1111;
        rst_n = 1'b0;
        @(negedge clk);
        compare('0, "R8 mid-run reset");
        finish_run();
    end

endmodule